// File: doc/BRIEF.md
# Display FIFO Refill Threshold Calculator

This block turns a set of clock-divider settings and memory timing figures into the two configuration words that govern when a display FIFO asks memory for more data. From the ratio of memory clock to pixel clock it derives a fixed-point scale, a "refill off" level, a "refill on" level and the number of memory clocks spent per 64-bit quadword. It then packs them with the loop latency into two 32-bit words, ready to be written into the display pipeline's control registers.

The calculation is sequential. A single `start` pulse latches every input. A small sequencer reduces the clock ratio to lowest even terms, then runs four divisions one after another through one shared restoring divider. It ends with a one-cycle `done` pulse. The two result words hold their value until the next `done`. All intermediate arithmetic is 48 bits wide.

Top module: `fifo_refill_calc`

## Requirements
- R1: A `start` seen while `busy` is low latches all inputs and raises `busy` on the next cycle. `done` is a single-cycle pulse with `busy` low in that cycle. A `start` or input change while `busy` is high has no effect on the result.
- R2: The ratio terms are M = mem_fb_div × pix_post_div and D = pix_fb_div × mem_ref_div. D is further multiplied by bpp/4 (integer) when bpp ≥ 8. Both are halved together while both are even.
- R3: The base shift is V = 4 − mem_post_code, less one more when bpp = 0.
- R4: The precision P is the bit length of ((M × fifo_size) << V) / D, minus 5, saturated to 0..7. It is reported in cfg_b bits 22:20. From P come S = 6 − P (which may be −1, meaning a right shift by one) and V2 = V + S.
- R5: The off level is ((M × (fifo_size − 1)) shifted by V2) / D − 2^V, in 48-bit wrap-around arithmetic. Its low 16 bits appear in cfg_a bits 15:0.
- R6: The on level starts as Q + 1, where Q = (M shifted by V2) / D. It is raised to T = (ras_delay shifted by S) + 1 if it is smaller than T. Then 2T and (pf_delay shifted by S) are added.
- R7: The granule G is 2^(6−P), or 1 when P = 7. The on level is rounded up to a multiple of G. If it is then not below the off level rounded down to a multiple of G, it becomes (off − Q) rounded down to a multiple of G. Its low 16 bits appear in cfg_a bits 31:16.
- R8: The clocks-per-quadword value is ((M shifted by V2 + 5) + D) / D. Its low 16 bits appear in cfg_b bits 15:0. loop_lat appears in cfg_b bits 19:16, and cfg_b bits 31:23 are zero.
- R9: cfg_a and cfg_b change only in the cycle `done` is high. They keep their value afterwards.
- R10: Synchronous active-high reset clears cfg_a, cfg_b, `busy` and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calculation when idle |
| mem_fb_div | input | 8 | Memory clock feedback divider |
| pix_fb_div | input | 8 | Pixel clock feedback divider |
| pix_post_div | input | 4 | Effective pixel post-divide value |
| mem_ref_div | input | 2 | Memory reference divider |
| mem_post_code | input | 2 | Memory post-divide code |
| bpp | input | 6 | Bits per pixel, 0 for narrow text mode |
| fifo_size | input | 6 | FIFO depth in quadwords |
| ras_delay | input | 4 | Row-activate delay in memory clocks |
| pf_delay | input | 4 | Page-fault delay in memory clocks |
| loop_lat | input | 4 | Loop latency, passed through to cfg_b |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| cfg_a | output | 32 | On level (31:16) and off level (15:0) |
| cfg_b | output | 32 | Precision, loop latency and clocks per quadword |

## Verification
The vectors cover several settings, and each one separates one behaviour from the others:
- A ratio small enough to pin the precision at zero, with delays large enough that the on level collides with the off level and takes the clamp path.
- A ratio large enough to saturate the precision at 7, which exercises the negative shift.
- A zero pixel depth, which takes the narrow-mode shift.
- A sub-8 pixel depth, which skips the depth factor.
- Odd divider values, which stop the normalization at once.
- Ordinary mid-range cases with no clamping.

Directed tests add the reset state, result hold after `done`, and a second `start` with changed inputs during a run, which must leave the first result untouched.

// File: rtl/fifo_refill_pkg.sv
package fifo_refill_pkg;
    localparam int DW       = 48;
    localparam int FBW      = 8;
    localparam int PDW      = 4;
    localparam int RDW      = 2;
    localparam int CW       = 2;
    localparam int BPW      = 6;
    localparam int FSW      = 6;
    localparam int DLW      = 4;
    localparam int PREC_MAX = 7;
    localparam int PREC_W   = 3;
    localparam int PH_W     = 2;

    typedef logic [DW-1:0] word_t;

    typedef enum logic [1:0] {ST_IDLE, ST_NORM, ST_DIV, ST_FIN} state_t;

    typedef struct packed {
        word_t            m;
        word_t            d;
        logic [2:0]       vsh;
        logic [FSW-1:0]   fifo;
        logic [DLW-1:0]   ras;
        logic [DLW-1:0]   pf;
        logic [DLW-1:0]   lat;
    } job_t;

    // left shift for s >= 0, right shift for s < 0
    function automatic word_t shift_by(word_t x, int s);
        if (s >= 0) return x << s;
        return x >> (-s);
    endfunction

    function automatic int bit_len(word_t x);
        int n;
        n = 0;
        for (int i = 0; i < DW; i++)
            if (x[i]) n = i + 1;
        return n;
    endfunction

    function automatic logic [PREC_W-1:0] pick_precision(word_t ratio);
        int p;
        p = bit_len(ratio) - 5;
        if (p < 0) p = 0;
        if (p > PREC_MAX) p = PREC_MAX;
        return PREC_W'(p);
    endfunction
endpackage

// File: rtl/fdc_divider.sv
module fdc_divider #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         fin,
    output logic [W-1:0] quo
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W:0]       rem;
    logic [W-1:0]     qreg;
    logic [W-1:0]     dreg;
    logic [CNT_W-1:0] cnt;
    logic [W:0]       rem_sh;
    logic             fits;

    assign rem_sh = {rem[W-1:0], qreg[W-1]};
    assign fits   = rem_sh >= {1'b0, dreg};
    assign quo    = qreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem  <= '0;
            qreg <= '0;
            dreg <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            fin  <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go && !busy) begin
                rem  <= '0;
                qreg <= num;
                dreg <= den;
                cnt  <= CNT_W'(W);
                busy <= 1'b1;
            end else if (busy) begin
                rem  <= fits ? (rem_sh - {1'b0, dreg}) : rem_sh;
                qreg <= {qreg[W-2:0], fits};
                cnt  <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fdc_granule.sv
module fdc_granule
    import fifo_refill_pkg::*;
(
    input  word_t             on_base,
    input  word_t             off_v,
    input  word_t             ras_term,
    input  word_t             pf_term,
    input  logic [PREC_W-1:0] prec,
    output word_t             on_fin
);
    logic [2:0] gsh;
    word_t      mask;
    word_t      floor_q;
    word_t      lifted;
    word_t      total;
    word_t      up;
    word_t      off_dn;

    always_comb begin
        gsh     = (prec == 3'(PREC_MAX)) ? 3'd0 : 3'(6 - int'(prec));
        mask    = ~((word_t'(1) << gsh) - word_t'(1));
        floor_q = on_base - word_t'(1);
        lifted  = (on_base < ras_term) ? ras_term : on_base;
        total   = lifted + (ras_term << 1) + pf_term;
        up      = (total + ~mask) & mask;
        off_dn  = off_v & mask;
        on_fin  = (up >= off_dn) ? ((off_v - floor_q) & mask) : up;
    end
endmodule

// File: rtl/fifo_refill_calc.sv
module fifo_refill_calc
    import fifo_refill_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [FBW-1:0] mem_fb_div,
    input  logic [FBW-1:0] pix_fb_div,
    input  logic [PDW-1:0] pix_post_div,
    input  logic [RDW-1:0] mem_ref_div,
    input  logic [CW-1:0]  mem_post_code,
    input  logic [BPW-1:0] bpp,
    input  logic [FSW-1:0] fifo_size,
    input  logic [DLW-1:0] ras_delay,
    input  logic [DLW-1:0] pf_delay,
    input  logic [DLW-1:0] loop_lat,
    output logic           busy,
    output logic           done,
    output logic [31:0]    cfg_a,
    output logic [31:0]    cfg_b
);
    state_t             st;
    job_t               job;
    logic [PH_W-1:0]    ph;
    logic               issued;
    logic [PREC_W-1:0]  prec_r;
    word_t              off_r;
    word_t              on0_r;
    word_t              xclk_r;

    logic               dv_go;
    logic               dv_busy;
    logic               dv_fin;
    word_t              dv_quo;
    word_t              numer;
    word_t              ras_term;
    word_t              pf_term;
    word_t              on_fin;
    word_t              d_init;
    int                 vs_i;
    int                 xs_i;
    int                 v2_i;

    assign busy  = (st != ST_IDLE);
    assign dv_go = (st == ST_DIV) && !issued;

    // initial ratio denominator with pixel-depth factor (R2)
    always_comb begin
        d_init = word_t'(pix_fb_div) * word_t'(mem_ref_div);
        if (bpp >= BPW'(8))
            d_init = d_init * word_t'(bpp >> 2);
    end

    // numerator for the current division phase
    always_comb begin
        vs_i = int'(job.vsh);
        xs_i = 6 - int'(prec_r);
        v2_i = vs_i + xs_i;
        unique case (ph)
            2'd0:    numer = (job.m * word_t'(job.fifo)) << job.vsh;
            2'd1:    numer = shift_by(job.m * word_t'(job.fifo - FSW'(1)), v2_i);
            2'd2:    numer = shift_by(job.m, v2_i) + job.d;
            default: numer = shift_by(job.m, v2_i + 5) + job.d;
        endcase
        ras_term = shift_by(word_t'(job.ras), xs_i) + word_t'(1);
        pf_term  = shift_by(word_t'(job.pf), xs_i);
    end

    fdc_divider #(.W(DW)) u_div (
        .clk  (clk),
        .rst  (rst),
        .go   (dv_go),
        .num  (numer),
        .den  (job.d),
        .busy (dv_busy),
        .fin  (dv_fin),
        .quo  (dv_quo)
    );

    fdc_granule u_gran (
        .on_base  (on0_r),
        .off_v    (off_r),
        .ras_term (ras_term),
        .pf_term  (pf_term),
        .prec     (prec_r),
        .on_fin   (on_fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            job    <= '0;
            ph     <= '0;
            issued <= 1'b0;
            prec_r <= '0;
            off_r  <= '0;
            on0_r  <= '0;
            xclk_r <= '0;
            done   <= 1'b0;
            cfg_a  <= '0;
            cfg_b  <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        job.m    <= word_t'(mem_fb_div) * word_t'(pix_post_div);
                        job.d    <= d_init;
                        job.vsh  <= 3'(4 - int'(mem_post_code) - ((bpp == '0) ? 1 : 0));
                        job.fifo <= fifo_size;
                        job.ras  <= ras_delay;
                        job.pf   <= pf_delay;
                        job.lat  <= loop_lat;
                        ph       <= '0;
                        issued   <= 1'b0;
                        st       <= ST_NORM;
                    end
                end
                ST_NORM: begin
                    if (job.m[0] || job.d[0] || job.m == '0 || job.d == '0) begin
                        st <= ST_DIV;
                    end else begin
                        job.m <= job.m >> 1;
                        job.d <= job.d >> 1;
                    end
                end
                ST_DIV: begin
                    if (dv_go && !dv_busy)
                        issued <= 1'b1;
                    if (dv_fin) begin
                        issued <= 1'b0;
                        unique case (ph)
                            2'd0:    prec_r <= pick_precision(dv_quo);
                            2'd1:    off_r  <= dv_quo - (word_t'(1) << job.vsh);
                            2'd2:    on0_r  <= dv_quo;
                            default: xclk_r <= dv_quo;
                        endcase
                        if (ph == PH_W'(3))
                            st <= ST_FIN;
                        else
                            ph <= ph + 1'b1;
                    end
                end
                default: begin
                    cfg_a <= {on_fin[15:0], off_r[15:0]};
                    cfg_b <= {9'd0, prec_r, job.lat, xclk_r[15:0]};
                    done  <= 1'b1;
                    st    <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/fifo_refill_calc_chk.sv
module fifo_refill_calc_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [31:0] cfg_a,
    input logic [31:0] cfg_b
);
    // R1: an accepted start makes the block busy on the next cycle
    a_r1_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R1: done lasts exactly one cycle
    a_r1_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R1: done is reported while idle
    a_r1_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9: results move only together with done
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(cfg_a) && $stable(cfg_b)));
endmodule

bind fifo_refill_calc fifo_refill_calc_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .cfg_a (cfg_a),
    .cfg_b (cfg_b)
);

// File: tb/fifo_refill_calc_test.sv
module fifo_refill_calc_test;
    localparam int CLK_P = 10;
    localparam longint M48 = 64'h0000_FFFF_FFFF_FFFF;

    typedef struct packed {
        logic [7:0] mfb;
        logic [7:0] pfb;
        logic [3:0] ppr;
        logic [1:0] mref;
        logic [1:0] code;
        logic [5:0] bpp;
        logic [5:0] fifo;
        logic [3:0] ras;
        logic [3:0] pf;
        logic [3:0] lat;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'd200, 8'd150, 4'd2, 2'd1, 2'd1, 6'd16, 6'd32, 4'd3,  4'd2,  4'd9},
        '{8'd128, 8'd255, 4'd1, 2'd3, 2'd0, 6'd32, 6'd24, 4'd15, 4'd15, 4'd10},
        '{8'd255, 8'd128, 4'd8, 2'd1, 2'd0, 6'd8,  6'd32, 4'd2,  4'd1,  4'd8},
        '{8'd180, 8'd200, 4'd4, 2'd1, 2'd2, 6'd0,  6'd24, 4'd4,  4'd3,  4'd11},
        '{8'd140, 8'd220, 4'd3, 2'd1, 2'd3, 6'd4,  6'd32, 4'd5,  4'd6,  4'd8},
        '{8'd129, 8'd131, 4'd1, 2'd1, 2'd1, 6'd8,  6'd24, 4'd3,  4'd3,  4'd10},
        '{8'd160, 8'd160, 4'd2, 2'd3, 2'd2, 6'd32, 6'd32, 4'd6,  4'd4,  4'd8},
        '{8'd250, 8'd130, 4'd8, 2'd1, 2'd3, 6'd24, 6'd24, 4'd7,  4'd5,  4'd11}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [7:0]  mem_fb_div, pix_fb_div;
    logic [3:0]  pix_post_div;
    logic [1:0]  mem_ref_div, mem_post_code;
    logic [5:0]  bpp, fifo_size;
    logic [3:0]  ras_delay, pf_delay, loop_lat;
    logic        busy, done;
    logic [31:0] cfg_a, cfg_b;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    fifo_refill_calc uut (
        .clk(clk), .rst(rst), .start(start),
        .mem_fb_div(mem_fb_div), .pix_fb_div(pix_fb_div),
        .pix_post_div(pix_post_div), .mem_ref_div(mem_ref_div),
        .mem_post_code(mem_post_code), .bpp(bpp), .fifo_size(fifo_size),
        .ras_delay(ras_delay), .pf_delay(pf_delay), .loop_lat(loop_lat),
        .busy(busy), .done(done), .cfg_a(cfg_a), .cfg_b(cfg_b)
    );

    function automatic longint sh(longint x, int s);
        return (s >= 0) ? ((x << s) & M48) : (x >> (-s));
    endfunction

    // expected results straight from the requirement formulas
    function automatic logic [63:0] model(vec_t v);
        longint m, d, tmp, off, q, on, t, gr, xc;
        int vs, p, xs, v2, bl, gs;
        m = longint'(v.mfb) * longint'(v.ppr);
        d = longint'(v.pfb) * longint'(v.mref);
        if (v.bpp >= 8) d = d * longint'(v.bpp / 4);
        vs = 4 - int'(v.code) - ((v.bpp == 0) ? 1 : 0);
        while (m != 0 && d != 0 && m % 2 == 0 && d % 2 == 0) begin
            m = m / 2; d = d / 2;
        end
        tmp = ((m * longint'(v.fifo)) << vs) / d;
        bl = 0;
        while (tmp != 0) begin bl++; tmp = tmp >> 1; end
        p = bl - 5;
        if (p < 0) p = 0;
        if (p > 7) p = 7;
        xs = 6 - p;
        v2 = vs + xs;
        off = (sh(m * longint'(v.fifo - 1), v2) / d - (64'sd1 << vs)) & M48;
        q = sh(m, v2) / d;
        on = q + 1;
        t = sh(longint'(v.ras), xs) + 1;
        if (on < t) on = t;
        on = on + 2 * t + sh(longint'(v.pf), xs);
        gs = (p == 7) ? 0 : 6 - p;
        gr = 64'sd1 << gs;
        on = ((on + gr - 1) / gr) * gr;
        if (on >= (off / gr) * gr)
            on = (((off - q) & M48) / gr) * gr;
        xc = (sh(m, v2 + 5) + d) / d;
        model = {on[15:0], off[15:0], 9'd0, 3'(p), v.lat, xc[15:0]};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic drive(vec_t v);
        mem_fb_div = v.mfb; pix_fb_div = v.pfb; pix_post_div = v.ppr;
        mem_ref_div = v.mref; mem_post_code = v.code; bpp = v.bpp;
        fifo_size = v.fifo; ras_delay = v.ras; pf_delay = v.pf; loop_lat = v.lat;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; break; end
        end
    endtask

    task automatic check_result(vec_t v);
        logic [63:0] e;
        e = model(v);
        check("R5 off level",        {16'd0, cfg_a[15:0]},  {16'd0, e[47:32]});
        check("R6 R7 on level",      {16'd0, cfg_a[31:16]}, {16'd0, e[63:48]});
        check("R4 precision",        {29'd0, cfg_b[22:20]}, {29'd0, e[22:20]});
        check("R8 clocks per qword", cfg_b,                 e[31:0]);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit ok;
        logic [31:0] ha, hb;
        rst = 1'b1; start = 1'b0;
        drive(VECS[0]);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 cfg_a reset", cfg_a, 32'd0);
        check("R10 cfg_b reset", cfg_b, 32'd0);
        check("R10 busy/done reset", {30'd0, busy, done}, 32'd0);

        // vector table: R2, R3, R4, R5, R6, R7, R8
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R1 busy after start", {31'd0, busy}, 32'd1);
            wait_done(ok);
            check("R1 done seen", {31'd0, ok}, 32'd1);
            check("R1 idle with done", {31'd0, busy}, 32'd0);
            check_result(VECS[i]);
        end

        // R9: results held after done
        ha = cfg_a; hb = cfg_b;
        repeat (6) @(negedge clk);
        check("R9 cfg_a held", cfg_a, ha);
        check("R9 cfg_b held", cfg_b, hb);
        check("R9 done dropped", {31'd0, done}, 32'd0);

        // R1: restart and input changes during a run are ignored
        drive(VECS[1]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        drive(VECS[2]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        check("R1 done after restart attempt", {31'd0, ok}, 32'd1);
        check_result(VECS[1]);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule